// File: doc/BRIEF.md
# Store-Load Ordering Checker

This block is the central, second-level store tracker that sits behind a fast, speculative first-level forwarding path. Every store gets a slot in a circular queue in program order when it is dispatched. It leaves the queue from the head when it commits. Its address and byte mask are filled in when it executes. The checker never supplies data to a load. Instead, each load tells the checker what it received from the first level: whether data was forwarded, and from which store tag. The checker then confirms or rejects that decision a fixed three cycles later.

For each load check, the checker searches the stores that are older than the load for executed stores at the same address whose byte mask overlaps the load's. It picks the youngest of them. If the first-level decision disagrees with that result, a violation is raised together with the load's identifier, and the pipeline uses this to start recovery. A flush discards all stores from a given tag onwards by pulling the tail pointer back.

Store tags are queue pointers with one extra wrap bit. A load's age is the store tail pointer value at the moment the load was dispatched. The stores older than a load are therefore those between the head and that age.

Top module: `stld_order_checker`

## Requirements
- R1: A store allocation request (`allocValid`) with no flush and a non-full queue assigns the store the tag shown on `allocTag`. After the next clock edge, `allocTag` has advanced by one, modulo twice the queue depth.
- R2: When the queue holds ENTRIES live stores, `storeFull` is 1, and an allocation request leaves `allocTag` unchanged.
- R3: A commit request (`commitValid`) with no flush removes the oldest live store, so a full queue stops reporting `storeFull`. A commit on an empty queue does nothing.
- R4: A flush (`flushValid`) with a tag between head and tail inclusive sets the tail to that tag, so `allocTag` equals it after the edge. A flush tag outside that range leaves the tail unchanged. During a flush cycle, allocation and commit requests are ignored.
- R5: A load check presented with `ldValid` in cycle k produces a one-cycle `chkValid` pulse in cycle k+3, with `chkLoadId` equal to the load's `ldId`. `chkValid` is low in cycles k+1 and k+2.
- R6: A store qualifies for a load when all of the following hold: it is live, its position lies before the load's age, it has executed, its address equals the load address, and its byte mask ANDed with the load mask is non-zero. A load that misses and has no qualifying store gets no violation.
- R7: When qualifying stores exist and the load reports a hit, there is no violation if the reported source tag equals the youngest qualifying store's tag, and a violation otherwise.
- R8: A load that reports a miss while a qualifying store exists is flagged as a violation.
- R9: A load that reports a hit while no qualifying store exists (including a store that has already committed) is flagged as a violation.
- R10: After reset the queue is empty: `allocTag` is 0, `storeFull` is 0 and `chkValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Allocate the next store slot |
| allocTag | output | PTR_W | Tag the next allocated store receives (tail pointer) |
| storeFull | output | 1 | All slots hold live stores |
| commitValid | input | 1 | Oldest store commits and is removed |
| flushValid | input | 1 | Squash stores from flushTag onwards |
| flushTag | input | PTR_W | First tag to be squashed |
| stExecValid | input | 1 | A store's address and mask become known |
| stExecTag | input | PTR_W | Tag of the executing store |
| stExecAddr | input | ADDR_W | Store address (aligned granule) |
| stExecMask | input | MASK_W | Bytes written within the granule |
| ldValid | input | 1 | A load check request |
| ldId | input | ID_W | Load identifier returned with the result |
| ldAge | input | PTR_W | Store tail pointer at load dispatch |
| ldAddr | input | ADDR_W | Load address (aligned granule) |
| ldMask | input | MASK_W | Bytes read within the granule |
| ldFwdHit | input | 1 | First level forwarded store data |
| ldFwdTag | input | PTR_W | Store tag the first level forwarded from |
| chkValid | output | 1 | Result pulse for a load check |
| chkViolation | output | 1 | Forwarding decision was wrong |
| chkLoadId | output | ID_W | Identifier of the checked load |

## Verification
A load check is registered on its sampling edge. The store search is registered on the next edge, and the verdict on the edge after that, so each result is due exactly three cycles after the load is driven. The bench drives inputs just after a falling edge and reads outputs at falling edges. The vector loop issues one load per cycle and compares the result for load s-3 at step s, which tests back-to-back pipelining. Queue effects (`allocTag`, `storeFull`) are due one edge after the request and are read at the next falling edge. A directed test reads `chkValid` at each of the four cycles after a lone load to confirm the exact latency.

// File: rtl/stld_pkg.sv
package stld_pkg;

  // Strobes passed from the queue control to the datapath.
  typedef struct packed {
    logic allocEn;   // clear the known flag of the tail slot
    logic execEn;    // write address/mask of a live slot
    logic stage1En;  // capture an incoming load check
    logic stage2En;  // capture the search result
    logic stage3En;  // capture the verdict
  } stld_strobe_t;

endpackage

// File: rtl/stld_ctrl.sv
module stld_ctrl
  import stld_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int PTR_W   = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             allocValid,
  input  logic             commitValid,
  input  logic             flushValid,
  input  logic [PTR_W-1:0] flushTag,
  input  logic             stExecValid,
  input  logic [PTR_W-1:0] stExecTag,
  input  logic             ldValid,
  output stld_strobe_t     strobe,
  output logic [PTR_W-1:0] headPtr,
  output logic [PTR_W-1:0] tailPtr,
  output logic [PTR_W-1:0] liveCount,
  output logic             full,
  output logic             chkValid
);

  localparam logic [PTR_W-1:0] DEPTH = PTR_W'(ENTRIES);
  localparam logic [PTR_W-1:0] ONE   = PTR_W'(1);

  logic [PTR_W-1:0] flushRel;
  logic [PTR_W-1:0] execRel;
  logic             flushOk;
  logic             commitOk;
  logic             allocOk;
  logic             execOk;
  logic             valid1;
  logic             valid2;
  logic             valid3;

  assign liveCount = tailPtr - headPtr;
  assign full      = (liveCount == DEPTH);
  assign flushRel  = flushTag - headPtr;
  assign execRel   = stExecTag - headPtr;

  // A flush request of any kind blocks allocation and commit this cycle.
  assign flushOk  = flushValid && (flushRel <= liveCount);
  assign allocOk  = allocValid && !flushValid && !full;
  assign commitOk = commitValid && !flushValid && (liveCount != '0);
  assign execOk   = stExecValid && (execRel < liveCount);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
    end else begin
      if (flushOk)       tailPtr <= flushTag;
      else if (allocOk)  tailPtr <= tailPtr + ONE;
      if (commitOk)      headPtr <= headPtr + ONE;
    end
  end

  // Fixed three-stage valid pipeline for load checks.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      valid1 <= 1'b0;
      valid2 <= 1'b0;
      valid3 <= 1'b0;
    end else begin
      valid1 <= ldValid;
      valid2 <= valid1;
      valid3 <= valid2;
    end
  end

  always_comb begin
    strobe.allocEn  = allocOk;
    strobe.execEn   = execOk;
    strobe.stage1En = ldValid;
    strobe.stage2En = valid1;
    strobe.stage3En = valid2;
  end

  assign chkValid = valid3;

  // R2: occupancy never exceeds the queue depth
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    liveCount <= DEPTH);

  // R1: an accepted allocation advances the tail by one
  a_r1_alloc_step: assert property (@(posedge clk) disable iff (!rstN)
    allocValid && !flushValid && !full |=> tailPtr == $past(tailPtr) + ONE);

  // R2: allocation against a full queue leaves the tail alone
  a_r2_full_hold: assert property (@(posedge clk) disable iff (!rstN)
    allocValid && !flushValid && full |=> tailPtr == $past(tailPtr));

  // R3: an accepted commit advances the head by one
  a_r3_commit_step: assert property (@(posedge clk) disable iff (!rstN)
    commitValid && !flushValid && liveCount != '0 |=> headPtr == $past(headPtr) + ONE);

  // R4: an in-range flush moves the tail to the flush tag
  a_r4_flush_tail: assert property (@(posedge clk) disable iff (!rstN)
    flushValid && (flushTag - headPtr) <= liveCount |=> tailPtr == $past(flushTag));

  // R5: every result pulse follows a load check three cycles earlier
  a_r5_latency: assert property (@(posedge clk) disable iff (!rstN)
    chkValid |-> $past(ldValid, 3));

endmodule

// File: rtl/stld_datapath.sv
module stld_datapath
  import stld_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4,
  parameter int PTR_W   = 5,
  parameter int ADDR_W  = 32,
  parameter int MASK_W  = 8,
  parameter int ID_W    = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  stld_strobe_t      strobe,
  input  logic [PTR_W-1:0]  headPtr,
  input  logic [PTR_W-1:0]  tailPtr,
  input  logic [PTR_W-1:0]  liveCount,
  input  logic [PTR_W-1:0]  stExecTag,
  input  logic [ADDR_W-1:0] stExecAddr,
  input  logic [MASK_W-1:0] stExecMask,
  input  logic [ID_W-1:0]   ldId,
  input  logic [PTR_W-1:0]  ldAge,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic [MASK_W-1:0] ldMask,
  input  logic              ldFwdHit,
  input  logic [PTR_W-1:0]  ldFwdTag,
  output logic              chkViolation,
  output logic [ID_W-1:0]   chkLoadId
);

  // Store storage, indexed by the low bits of the tag.
  logic [ADDR_W-1:0] entAddr  [ENTRIES];
  logic [MASK_W-1:0] entMask  [ENTRIES];
  logic [ENTRIES-1:0] entKnown;

  logic [IDX_W-1:0] allocIdx;
  logic [IDX_W-1:0] execIdx;
  assign allocIdx = tailPtr[IDX_W-1:0];
  assign execIdx  = stExecTag[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entKnown <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        entAddr[i] <= '0;
        entMask[i] <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (strobe.execEn && execIdx == IDX_W'(i)) begin
          entKnown[i] <= 1'b1;
          entAddr[i]  <= stExecAddr;
          entMask[i]  <= stExecMask;
        end else if (strobe.allocEn && allocIdx == IDX_W'(i)) begin
          entKnown[i] <= 1'b0;
        end
      end
    end
  end

  // Stage 1: captured load check.
  logic [ID_W-1:0]   s1Id;
  logic [PTR_W-1:0]  s1Age;
  logic [ADDR_W-1:0] s1Addr;
  logic [MASK_W-1:0] s1Mask;
  logic              s1Hit;
  logic [PTR_W-1:0]  s1Src;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Id <= '0; s1Age <= '0; s1Addr <= '0;
      s1Mask <= '0; s1Hit <= 1'b0; s1Src <= '0;
    end else if (strobe.stage1En) begin
      s1Id   <= ldId;
      s1Age  <= ldAge;
      s1Addr <= ldAddr;
      s1Mask <= ldMask;
      s1Hit  <= ldFwdHit;
      s1Src  <= ldFwdTag;
    end
  end

  // Search: position r counts from the head (0 = oldest).
  logic [PTR_W-1:0]   ageRel;
  logic [ENTRIES-1:0] matchRel;
  assign ageRel = s1Age - headPtr;

  for (genvar r = 0; r < ENTRIES; r++) begin : g_match
    logic [IDX_W-1:0] slot;
    logic             older;
    assign slot  = headPtr[IDX_W-1:0] + IDX_W'(r);
    assign older = (PTR_W'(r) < liveCount) && (PTR_W'(r) < ageRel);
    assign matchRel[r] = older && entKnown[slot] &&
                         (entAddr[slot] == s1Addr) &&
                         ((entMask[slot] & s1Mask) != '0);
  end

  logic             expHit;
  logic [IDX_W-1:0] expRel;
  logic [PTR_W-1:0] expTag;

  always_comb begin
    expHit = 1'b0;
    expRel = '0;
    for (int r = 0; r < ENTRIES; r++) begin
      if (matchRel[r]) begin
        expHit = 1'b1;
        expRel = IDX_W'(r);   // later positions are younger and win
      end
    end
  end
  assign expTag = headPtr + PTR_W'(expRel);

  // Stage 2: search result next to the reported decision.
  logic [ID_W-1:0]  s2Id;
  logic             s2Hit;
  logic [PTR_W-1:0] s2Src;
  logic             s2ExpHit;
  logic [PTR_W-1:0] s2ExpTag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s2Id <= '0; s2Hit <= 1'b0; s2Src <= '0;
      s2ExpHit <= 1'b0; s2ExpTag <= '0;
    end else if (strobe.stage2En) begin
      s2Id     <= s1Id;
      s2Hit    <= s1Hit;
      s2Src    <= s1Src;
      s2ExpHit <= expHit;
      s2ExpTag <= expTag;
    end
  end

  // Stage 3: verdict.
  logic verdict;
  assign verdict = (s2Hit != s2ExpHit) || (s2Hit && (s2Src != s2ExpTag));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chkViolation <= 1'b0;
      chkLoadId    <= '0;
    end else begin
      chkViolation <= strobe.stage3En && verdict;
      if (strobe.stage3En) chkLoadId <= s2Id;
    end
  end

  // R6: a found source is always a live store older than the load
  a_r6_source_live: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stage2En && expHit |-> ((expTag - headPtr) < liveCount) &&
                                  ((expTag - headPtr) < ageRel));

  // R9: a forwarded hit with no qualifying store is flagged
  a_r9_hit_without_store: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stage3En && s2Hit && !s2ExpHit |=> chkViolation);

  // R8: a miss with a qualifying store is flagged
  a_r8_miss_with_store: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stage3En && !s2Hit && s2ExpHit |=> chkViolation);

  // R7: agreeing source tags give a clean result
  a_r7_matching_source: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stage3En && s2Hit && s2ExpHit && (s2Src == s2ExpTag) |=> !chkViolation);

endmodule

// File: rtl/stld_order_checker.sv
module stld_order_checker
  import stld_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32,
  parameter int MASK_W  = 8,
  parameter int ID_W    = 6,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int PTR_W  = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocValid,
  output logic [PTR_W-1:0]  allocTag,
  output logic              storeFull,
  input  logic              commitValid,
  input  logic              flushValid,
  input  logic [PTR_W-1:0]  flushTag,
  input  logic              stExecValid,
  input  logic [PTR_W-1:0]  stExecTag,
  input  logic [ADDR_W-1:0] stExecAddr,
  input  logic [MASK_W-1:0] stExecMask,
  input  logic              ldValid,
  input  logic [ID_W-1:0]   ldId,
  input  logic [PTR_W-1:0]  ldAge,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic [MASK_W-1:0] ldMask,
  input  logic              ldFwdHit,
  input  logic [PTR_W-1:0]  ldFwdTag,
  output logic              chkValid,
  output logic              chkViolation,
  output logic [ID_W-1:0]   chkLoadId
);

  stld_strobe_t     strobe;
  logic [PTR_W-1:0] headPtr;
  logic [PTR_W-1:0] tailPtr;
  logic [PTR_W-1:0] liveCount;

  stld_ctrl #(
    .ENTRIES (ENTRIES),
    .PTR_W   (PTR_W)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .allocValid  (allocValid),
    .commitValid (commitValid),
    .flushValid  (flushValid),
    .flushTag    (flushTag),
    .stExecValid (stExecValid),
    .stExecTag   (stExecTag),
    .ldValid     (ldValid),
    .strobe      (strobe),
    .headPtr     (headPtr),
    .tailPtr     (tailPtr),
    .liveCount   (liveCount),
    .full        (storeFull),
    .chkValid    (chkValid)
  );

  stld_datapath #(
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W),
    .PTR_W   (PTR_W),
    .ADDR_W  (ADDR_W),
    .MASK_W  (MASK_W),
    .ID_W    (ID_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .headPtr      (headPtr),
    .tailPtr      (tailPtr),
    .liveCount    (liveCount),
    .stExecTag    (stExecTag),
    .stExecAddr   (stExecAddr),
    .stExecMask   (stExecMask),
    .ldId         (ldId),
    .ldAge        (ldAge),
    .ldAddr       (ldAddr),
    .ldMask       (ldMask),
    .ldFwdHit     (ldFwdHit),
    .ldFwdTag     (ldFwdTag),
    .chkViolation (chkViolation),
    .chkLoadId    (chkLoadId)
  );

  assign allocTag = tailPtr;

endmodule

// File: tb/stld_order_checker_tb.sv
`timescale 1ns/1ps
module stld_order_checker_tb;

  localparam int PTR_W  = 5;
  localparam int ADDR_W = 32;
  localparam int MASK_W = 8;
  localparam int ID_W   = 6;
  localparam int NV     = 12;

  logic              clk = 1'b0;
  logic              rstN;
  logic              allocValid;
  logic [PTR_W-1:0]  allocTag;
  logic              storeFull;
  logic              commitValid;
  logic              flushValid;
  logic [PTR_W-1:0]  flushTag;
  logic              stExecValid;
  logic [PTR_W-1:0]  stExecTag;
  logic [ADDR_W-1:0] stExecAddr;
  logic [MASK_W-1:0] stExecMask;
  logic              ldValid;
  logic [ID_W-1:0]   ldId;
  logic [PTR_W-1:0]  ldAge;
  logic [ADDR_W-1:0] ldAddr;
  logic [MASK_W-1:0] ldMask;
  logic              ldFwdHit;
  logic [PTR_W-1:0]  ldFwdTag;
  logic              chkValid;
  logic              chkViolation;
  logic [ID_W-1:0]   chkLoadId;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  stld_order_checker u_dut (
    .clk(clk), .rstN(rstN),
    .allocValid(allocValid), .allocTag(allocTag), .storeFull(storeFull),
    .commitValid(commitValid), .flushValid(flushValid), .flushTag(flushTag),
    .stExecValid(stExecValid), .stExecTag(stExecTag),
    .stExecAddr(stExecAddr), .stExecMask(stExecMask),
    .ldValid(ldValid), .ldId(ldId), .ldAge(ldAge), .ldAddr(ldAddr),
    .ldMask(ldMask), .ldFwdHit(ldFwdHit), .ldFwdTag(ldFwdTag),
    .chkValid(chkValid), .chkViolation(chkViolation), .chkLoadId(chkLoadId)
  );

  // Fields: age, addr, mask, fwd hit, fwd tag, expected violation.
  // Stores: t0 @10 m0F, t1 @20 mFF, t2 @10 mF0, t3 @10 m0C, t4 unexecuted, t5 @30 m01.
  localparam logic [27:0] VEC [NV] = '{
    {5'd6, 8'h10, 8'h03, 1'b1, 5'd0, 1'b0},  // R6 only t0 overlaps
    {5'd6, 8'h10, 8'h03, 1'b1, 5'd3, 1'b1},  // R7 wrong source
    {5'd6, 8'h10, 8'h0C, 1'b1, 5'd3, 1'b0},  // R7 youngest is t3
    {5'd3, 8'h10, 8'h0C, 1'b1, 5'd0, 1'b0},  // R6 t3 is younger than load
    {5'd6, 8'h10, 8'h80, 1'b0, 5'd0, 1'b1},  // R8 miss but t2 overlaps
    {5'd2, 8'h10, 8'h80, 1'b0, 5'd0, 1'b0},  // R6 no older overlap
    {5'd2, 8'h10, 8'h80, 1'b1, 5'd0, 1'b1},  // R9 hit with no source
    {5'd6, 8'h40, 8'hFF, 1'b0, 5'd0, 1'b0},  // R6 address differs
    {5'd6, 8'h30, 8'h01, 1'b1, 5'd5, 1'b0},  // R7 correct source t5
    {5'd5, 8'h30, 8'h01, 1'b0, 5'd0, 1'b0},  // R6 t5 younger
    {5'd0, 8'h20, 8'hFF, 1'b0, 5'd0, 1'b0},  // R6 age zero sees nothing
    {5'd6, 8'h20, 8'h0F, 1'b1, 5'd1, 1'b0}   // R7 correct source t1
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    allocValid = 0; commitValid = 0; flushValid = 0; flushTag = '0;
    stExecValid = 0; stExecTag = '0; stExecAddr = '0; stExecMask = '0;
    ldValid = 0; ldId = '0; ldAge = '0; ldAddr = '0; ldMask = '0;
    ldFwdHit = 0; ldFwdTag = '0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic execStore(int tag, int addr, int mask);
    idle();
    stExecValid = 1; stExecTag = PTR_W'(tag);
    stExecAddr = ADDR_W'(addr); stExecMask = MASK_W'(mask);
    step();
  endtask

  task automatic finish();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8ns * 200000);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish();
  end

  initial begin
    idle();
    rstN = 0;
    repeat (3) step();
    rstN = 1;
    step();
    // R10 reset state
    check("R10 allocTag", 32'(allocTag), 0);
    check("R10 storeFull", 32'(storeFull), 0);
    check("R10 chkValid", 32'(chkValid), 0);

    // R1 six allocations in order
    for (int i = 0; i < 6; i++) begin
      idle(); allocValid = 1; step();
      check("R1 allocTag", 32'(allocTag), 32'(i + 1));
    end
    execStore(0, 'h10, 'h0F);
    execStore(1, 'h20, 'hFF);
    execStore(2, 'h10, 'hF0);
    execStore(3, 'h10, 'h0C);
    execStore(5, 'h30, 'h01);
    idle();
    step();

    // Vector walk: one load per cycle, result checked three steps later (R5)
    for (int s = 0; s < NV + 3; s++) begin
      if (s >= 3) begin
        check("R5 chkValid", 32'(chkValid), 1);
        check("R5 chkLoadId", 32'(chkLoadId), 32'(s - 3));
        check($sformatf("R6-8 verdict vec%0d", s - 3), 32'(chkViolation),
              32'(VEC[s-3][0]));
      end else begin
        check("R5 chkValid early", 32'(chkValid), 0);
      end
      idle();
      if (s < NV) begin
        ldValid  = 1;
        ldId     = ID_W'(s);
        ldAge    = VEC[s][27:23];
        ldAddr   = ADDR_W'(VEC[s][22:15]);
        ldMask   = VEC[s][14:7];
        ldFwdHit = VEC[s][6];
        ldFwdTag = VEC[s][5:1];
      end
      step();
    end
    idle();
    step();

    // R2 fill the queue
    for (int i = 0; i < 10; i++) begin
      idle(); allocValid = 1; step();
    end
    check("R2 allocTag full", 32'(allocTag), 16);
    check("R2 storeFull", 32'(storeFull), 1);
    idle(); allocValid = 1; step();
    check("R2 alloc ignored", 32'(allocTag), 16);

    // R3 commit frees a slot
    idle(); commitValid = 1; step();
    check("R3 storeFull cleared", 32'(storeFull), 0);
    idle(); allocValid = 1; step();
    check("R3 alloc after commit", 32'(allocTag), 17);
    check("R3 full again", 32'(storeFull), 1);

    // R4 flush wins over alloc and commit
    idle(); flushValid = 1; flushTag = 5'd8; allocValid = 1; commitValid = 1; step();
    check("R4 allocTag after flush", 32'(allocTag), 8);
    check("R4 storeFull after flush", 32'(storeFull), 0);
    idle(); flushValid = 1; flushTag = 5'd20; step();
    check("R4 out-of-range flush", 32'(allocTag), 8);

    // R9 source t0 has committed; R5 exact latency of a lone load
    idle();
    ldValid = 1; ldId = 6'd33; ldAge = 5'd8; ldAddr = 'h10;
    ldMask = 8'h01; ldFwdHit = 1; ldFwdTag = 5'd0;
    step();
    idle();
    check("R5 valid at +1", 32'(chkValid), 0);
    step();
    check("R5 valid at +2", 32'(chkValid), 0);
    step();
    check("R5 valid at +3", 32'(chkValid), 1);
    check("R5 id at +3", 32'(chkLoadId), 33);
    check("R9 committed source", 32'(chkViolation), 1);
    step();
    check("R5 valid at +4", 32'(chkValid), 0);

    // R3 drain fully, then extra commit on empty must not disturb occupancy
    for (int i = 0; i < 7; i++) begin
      idle(); commitValid = 1; step();
    end
    idle(); commitValid = 1; step();
    for (int i = 0; i < 15; i++) begin
      idle(); allocValid = 1; step();
    end
    check("R3 empty commit ignored", 32'(storeFull), 0);
    idle(); allocValid = 1; step();
    check("R3 full at depth", 32'(storeFull), 1);

    finish();
  end

endmodule